// File: doc/BRIEF.md
# Sixteen-Bit Compare/Capture Timer Channel

This block is one timer channel with a counter and two event slots. The counter is driven by a prescaled system clock or by a synchronised external clock input. Each slot holds a general register and a buffer register. In compare mode, a slot watches the counter and changes its pin output on a match. In capture mode, a slot latches the counter on an edge of its capture input. A match or capture on either slot can reset the counter, so the channel can run as a period timer.

Software sees the channel through a small register port. The port has a 4-bit address, a write strobe, a read strobe and combinational read data. Each slot event and each counter wrap sets a status flag. The interrupt output is the OR of the flags whose enables are set. The block also fixes which action wins when a software access lands in the same cycle as a count, capture, compare or buffer transfer.

Top module: `ccTimer`

## Requirements
- R1: With CTRL (address 0) bit 2 at 0, the counter advances on every 1st, 4th, 16th or 64th system clock, as CTRL[1:0] = 0, 1, 2 or 3 selects. The prescaler runs freely, so any 64-clock window holds exactly 64/divisor advances.
- R2: With CTRL bit 2 at 1, the counter advances on edges of the external clock input after a two-flop synchroniser. CTRL[4:3] picks the edge: 0 rising, 1 falling, 2 or 3 both.
- R3: A slot is in compare mode when its mode register (A at address 1, B at address 2) has bit 0 = 0. A match occurs when the counter equals the slot's general register (A at 6, B at 7) at an advance. The match sets the slot's flag (FLAGS at address 4, bit 0 for A, bit 1 for B). It also applies mode[2:1] to the slot's pin (cmpOut[0] for A, cmpOut[1] for B): 0 hold, 1 drive low, 2 drive high, 3 toggle. Both pins are low after reset.
- R4: A slot is in capture mode when mode bit 0 = 1. The edge that mode[4:3] picks on its capIn bit (0 rising, 1 falling, 2 or 3 both) passes through a two-flop synchroniser. It then loads the counter value into the general register and sets the slot's flag.
- R5: CTRL[6:5] = 1 clears the counter on an event of slot A, and 2 clears it on an event of slot B. Values 0 and 3 leave the counter free-running. The clear replaces the advance.
- R6: An advance from all ones wraps the counter to 0 and sets FLAGS bit 2. If a clear happens in the same cycle, the flag is not set.
- R7: A write to the counter (address 5) wins over an advance or a clear in the same cycle.
- R8: A capture wins over a write to the same general register in the same cycle, and the write is lost. A read of that register in that cycle returns the value being captured.
- R9: A write to a general register in the cycle of its compare match takes effect, and the match still sets the flag.
- R10: With mode bit 5 = 1 in compare mode, a match copies the buffer register (A at 8, B at 9) into the general register.
- R11: With mode bit 5 = 1 in capture mode, a capture moves the old general register value into the buffer register.
- R12: A flag bit clears only when 0 is written to it after a read of FLAGS that returned it as 1. Writing 1, or writing 0 without that read, leaves it set. An event in the same cycle as the clearing write wins.
- R13: The irq output is high while any flag is set whose enable bit in IEN (address 3) is set. Bit 0 enables A, bit 1 enables B, and bit 2 enables the wrap flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 4 | Register address |
| regWr | input | 1 | Write strobe |
| regRd | input | 1 | Read strobe (arms flag clearing) |
| regWrData | input | WIDTH | Write data |
| regRdData | output | WIDTH | Combinational read data |
| extClkIn | input | 1 | External count clock |
| capIn | input | 2 | Capture inputs, bit 0 slot A, bit 1 slot B |
| cmpOut | output | 2 | Compare pin outputs, bit 0 slot A |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the channel with WIDTH = 8. This brings the counter wrap, and a clear that coincides with the wrap, within a few hundred cycles. It also lets the bench compute every expected count as plain modular arithmetic. The bench sweeps every prescale setting, every external edge choice, every pin action, every capture sense, and both clear sources over several periods. It then places software writes exactly on the cycles of a capture, a match and a clear.

// File: rtl/ccTimerPkg.sv
package ccTimerPkg;
  localparam int NCH = 2;
  localparam int FLAG_W = NCH + 1;
  localparam int CTRL_W = 7;
  localparam int MODE_W = 6;

  localparam logic [3:0] A_CTRL  = 4'd0;
  localparam logic [3:0] A_MODEA = 4'd1;
  localparam logic [3:0] A_MODEB = 4'd2;
  localparam logic [3:0] A_IEN   = 4'd3;
  localparam logic [3:0] A_FLAGS = 4'd4;
  localparam logic [3:0] A_CNT   = 4'd5;
  localparam logic [3:0] A_GRA   = 4'd6;
  localparam logic [3:0] A_GRB   = 4'd7;
  localparam logic [3:0] A_BUFA  = 4'd8;
  localparam logic [3:0] A_BUFB  = 4'd9;

  typedef enum logic [1:0] {ACT_HOLD, ACT_LOW, ACT_HIGH, ACT_TOGGLE} outAct_e;

  typedef struct packed {
    logic       bufEn;
    logic [1:0] capSense;
    outAct_e    outAct;
    logic       isCapture;
  } chanCfg_t;

  typedef struct packed {
    logic [1:0] clrSel;
    logic [1:0] edgeSel;
    logic       extSel;
    logic [1:0] preSel;
  } tmrCtrl_t;

  typedef struct packed {
    logic           tick;
    logic [NCH-1:0] capEvt;
  } tmrStrobe_t;
endpackage

// File: rtl/ccTimerCtrl.sv
module ccTimerCtrl
  import ccTimerPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgWr,
  input  logic [3:0]            cfgAddr,
  input  logic [CTRL_W-1:0]     cfgData,
  input  logic                  extClkIn,
  input  logic [NCH-1:0]        capIn,
  output tmrCtrl_t              ctrlQ,
  output chanCfg_t [NCH-1:0]    chanQ,
  output logic [FLAG_W-1:0]     ienQ,
  output tmrStrobe_t            strobe
);
  localparam int PRE_W = 6;
  localparam int NIN = NCH + 1;

  logic [PRE_W-1:0] preCnt;
  logic             preTick;
  logic [NIN-1:0]   rawIn, syncOut, prevQ, riseV, fallV;

  function automatic logic senseHit(input logic [1:0] sel, input logic r, input logic f);
    case (sel)
      2'd0:    return r;
      2'd1:    return f;
      default: return r | f;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ <= '0;
      chanQ <= '0;
      ienQ  <= '0;
    end else if (cfgWr) begin
      if (cfgAddr == A_CTRL) ctrlQ <= tmrCtrl_t'(cfgData);
      if (cfgAddr == A_IEN)  ienQ  <= cfgData[FLAG_W-1:0];
      for (int i = 0; i < NCH; i++)
        if (cfgAddr == 4'(A_MODEA + i)) chanQ[i] <= chanCfg_t'(cfgData[MODE_W-1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) preCnt <= '0;
    else       preCnt <= preCnt + 1'b1;
  end

  always_comb begin
    case (ctrlQ.preSel)
      2'd0:    preTick = 1'b1;
      2'd1:    preTick = &preCnt[1:0];
      2'd2:    preTick = &preCnt[3:0];
      default: preTick = &preCnt[5:0];
    endcase
  end

  assign rawIn = {extClkIn, capIn};

  for (genvar g = 0; g < NIN; g++) begin : gSync
    logic [SYNC_STAGES-1:0] shiftQ;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        shiftQ   <= '0;
        prevQ[g] <= 1'b0;
      end else begin
        shiftQ   <= {shiftQ[SYNC_STAGES-2:0], rawIn[g]};
        prevQ[g] <= shiftQ[SYNC_STAGES-1];
      end
    end
    assign syncOut[g] = shiftQ[SYNC_STAGES-1];
    assign riseV[g]   = syncOut[g] & ~prevQ[g];
    assign fallV[g]   = ~syncOut[g] & prevQ[g];
  end

  always_comb begin
    strobe.tick = ctrlQ.extSel ? senseHit(ctrlQ.edgeSel, riseV[NCH], fallV[NCH]) : preTick;
    for (int i = 0; i < NCH; i++)
      strobe.capEvt[i] = chanQ[i].isCapture & senseHit(chanQ[i].capSense, riseV[i], fallV[i]);
  end
endmodule

// File: rtl/ccTimerDpath.sv
module ccTimerDpath
  import ccTimerPkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  tmrStrobe_t                  strobe,
  input  logic [1:0]                  clrSel,
  input  logic [NCH-1:0]              isCapV,
  input  logic [NCH-1:0]              bufEnV,
  input  logic [NCH-1:0][1:0]         actV,
  input  logic                        regWr,
  input  logic                        regRd,
  input  logic [3:0]                  regAddr,
  input  logic [WIDTH-1:0]            regWrData,
  output logic [WIDTH-1:0]            cntQ,
  output logic [NCH-1:0][WIDTH-1:0]   grQ,
  output logic [NCH-1:0][WIDTH-1:0]   bufQ,
  output logic [FLAG_W-1:0]           flagQ,
  output logic [NCH-1:0]              pinQ
);
  logic [NCH-1:0]    match, evt, wrGr, wrBuf;
  logic              wrCnt, clrNow, ovfNow;
  logic [FLAG_W-1:0] armedQ, setV, clrMask, armNew;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      match[i] = strobe.tick & ~isCapV[i] & (cntQ == grQ[i]);
      evt[i]   = match[i] | strobe.capEvt[i];
      wrGr[i]  = regWr & (regAddr == 4'(A_GRA + i));
      wrBuf[i] = regWr & (regAddr == 4'(A_BUFA + i));
    end
    wrCnt   = regWr & (regAddr == A_CNT);
    clrNow  = (clrSel == 2'd1 && evt[0]) || (clrSel == 2'd2 && evt[1]);
    ovfNow  = strobe.tick & (&cntQ) & ~clrNow & ~wrCnt;
    setV    = {ovfNow, evt};
    clrMask = (regWr && regAddr == A_FLAGS) ? (~regWrData[FLAG_W-1:0] & armedQ) : '0;
    armNew  = (regRd && regAddr == A_FLAGS) ? flagQ : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            cntQ <= '0;
    else if (wrCnt)       cntQ <= regWrData;
    else if (clrNow)      cntQ <= '0;
    else if (strobe.tick) cntQ <= cntQ + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grQ  <= '1;
      bufQ <= '1;
      pinQ <= '0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (strobe.capEvt[i])             grQ[i] <= cntQ;
        else if (wrGr[i])                 grQ[i] <= regWrData;
        else if (match[i] && bufEnV[i])   grQ[i] <= bufQ[i];

        if (strobe.capEvt[i] && bufEnV[i]) bufQ[i] <= grQ[i];
        else if (wrBuf[i])                 bufQ[i] <= regWrData;

        if (match[i]) begin
          case (actV[i])
            2'd1:    pinQ[i] <= 1'b0;
            2'd2:    pinQ[i] <= 1'b1;
            2'd3:    pinQ[i] <= ~pinQ[i];
            default: pinQ[i] <= pinQ[i];
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ  <= '0;
      armedQ <= '0;
    end else begin
      flagQ  <= (flagQ & ~clrMask) | setV;
      armedQ <= (armedQ | armNew) & ~clrMask;
    end
  end
endmodule

// File: rtl/ccTimer.sv
module ccTimer
  import ccTimerPkg::*;
#(
  parameter int WIDTH = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       regAddr,
  input  logic             regWr,
  input  logic             regRd,
  input  logic [WIDTH-1:0] regWrData,
  output logic [WIDTH-1:0] regRdData,
  input  logic             extClkIn,
  input  logic [1:0]       capIn,
  output logic [1:0]       cmpOut,
  output logic             irq
);
  tmrCtrl_t                 ctrlQ;
  chanCfg_t [NCH-1:0]       chanQ;
  logic [FLAG_W-1:0]        ienQ, flagQ;
  tmrStrobe_t               strobe;
  logic [WIDTH-1:0]         cntQ;
  logic [NCH-1:0][WIDTH-1:0] grQ, bufQ;
  logic [NCH-1:0]           isCapV, bufEnV;
  logic [NCH-1:0][1:0]      actV;

  ccTimerCtrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgWr(regWr), .cfgAddr(regAddr),
    .cfgData(regWrData[CTRL_W-1:0]), .extClkIn(extClkIn), .capIn(capIn),
    .ctrlQ(ctrlQ), .chanQ(chanQ), .ienQ(ienQ), .strobe(strobe)
  );

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      isCapV[i] = chanQ[i].isCapture;
      bufEnV[i] = chanQ[i].bufEn;
      actV[i]   = chanQ[i].outAct;
    end
  end

  ccTimerDpath #(.WIDTH(WIDTH)) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .clrSel(ctrlQ.clrSel),
    .isCapV(isCapV), .bufEnV(bufEnV), .actV(actV),
    .regWr(regWr), .regRd(regRd), .regAddr(regAddr), .regWrData(regWrData),
    .cntQ(cntQ), .grQ(grQ), .bufQ(bufQ), .flagQ(flagQ), .pinQ(cmpOut)
  );

  always_comb begin
    case (regAddr)
      A_CTRL:  regRdData = WIDTH'(ctrlQ);
      A_MODEA: regRdData = WIDTH'(chanQ[0]);
      A_MODEB: regRdData = WIDTH'(chanQ[1]);
      A_IEN:   regRdData = WIDTH'(ienQ);
      A_FLAGS: regRdData = WIDTH'(flagQ);
      A_CNT:   regRdData = cntQ;
      A_GRA:   regRdData = strobe.capEvt[0] ? cntQ : grQ[0];
      A_GRB:   regRdData = strobe.capEvt[1] ? cntQ : grQ[1];
      A_BUFA:  regRdData = bufQ[0];
      A_BUFB:  regRdData = bufQ[1];
      default: regRdData = '0;
    endcase
  end

  assign irq = |(flagQ & ienQ);
endmodule

// File: rtl/ccTimerChk.sv
module ccTimerChk
  import ccTimerPkg::*;
#(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWr,
  input logic [3:0]       regAddr,
  input logic [WIDTH-1:0] regWrData,
  input logic [WIDTH-1:0] cntQ,
  input logic [WIDTH-1:0] grA,
  input logic [WIDTH-1:0] bufA,
  input logic [FLAG_W-1:0] flagQ,
  input logic             tick,
  input logic             capA,
  input logic             bufEnA
);
  // R7
  cnt_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == A_CNT) |=> cntQ == $past(regWrData));

  // R1
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!(regWr && regAddr == A_CNT) && !tick) |=> (cntQ == $past(cntQ) || cntQ == '0));

  // R4
  cap_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    capA |=> grA == $past(cntQ));

  // R11
  cap_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    (capA && bufEnA) |=> bufA == $past(grA));

  // R6
  wrap_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagQ[NCH]) |-> ($past(cntQ) == {WIDTH{1'b1}} && cntQ == '0));

  // R12
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flagQ[0]) |-> $past(regWr && regAddr == A_FLAGS && !regWrData[0]));
endmodule

bind ccTimer ccTimerChk #(.WIDTH(WIDTH)) uChk (
  .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWrData(regWrData),
  .cntQ(cntQ), .grA(grQ[0]), .bufA(bufQ[0]), .flagQ(flagQ),
  .tick(strobe.tick), .capA(strobe.capEvt[0]), .bufEnA(chanQ[0].bufEn)
);

// File: tb/ccTimer_test.sv
module ccTimer_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0, rstN = 1'b0, regWr = 1'b0, regRd = 1'b0;
  logic [3:0] regAddr = '0;
  logic [W-1:0] regWrData = '0;
  logic [W-1:0] regRdData;
  logic extClkIn = 1'b0;
  logic [1:0] capIn = '0;
  logic [1:0] cmpOut;
  logic irq;
  int nChk = 0, nBad = 0;

  ccTimer #(.WIDTH(W)) uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWrData(regWrData), .regRdData(regRdData), .extClkIn(extClkIn),
    .capIn(capIn), .cmpOut(cmpOut), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    regAddr = 4'(a); regWrData = W'(d); regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic peek(input int a, output int v);
    regAddr = 4'(a);
    #1 v = int'(regRdData);
  endtask

  task automatic chkReg(input string tag, input int a, input int exp);
    int v;
    peek(a, v);
    check(tag, v, exp);
  endtask

  task automatic readFlags();
    regAddr = 4'd4; regRd = 1'b1;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic clearFlags();
    readFlags();
    wr(4, 0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int acts[5];
    int pins[5];
    int gvals[3];
    int v;
    acts = '{2, 0, 1, 3, 3};
    pins = '{1, 1, 0, 1, 0};
    gvals = '{5, 20, 33};

    // reset state (R3 pins low)
    idle(2);
    chkReg("R1 reset count", 5, 0);
    chkReg("R3 reset GRA", 6, 255);
    chkReg("R12 reset flags", 4, 0);
    check("R3 reset pins", int'(cmpOut), 0);
    check("R13 reset irq", int'(irq), 0);
    @(negedge clk);
    rstN = 1'b1;

    // R1 prescale sweep
    wr(1, 1); wr(2, 1);
    for (int s = 0; s < 4; s++) begin
      wr(0, s);
      wr(5, 0);
      idle(64);
      chkReg("R1 prescale", 5, 64 >> (2 * s));
    end

    // R2 external clock edge sweep
    for (int e = 0; e < 4; e++) begin
      wr(0, 4 | (e << 3));
      wr(5, 0);
      for (int p = 0; p < 5; p++) begin
        extClkIn = 1'b1; idle(3);
        extClkIn = 1'b0; idle(3);
      end
      idle(4);
      chkReg("R2 ext edges", 5, (e >= 2) ? 10 : 5);
    end

    // R3 compare pin actions with exact timing
    wr(0, 4); wr(5, 128); wr(6, 10); wr(0, 0);
    for (int r = 0; r < 5; r++) begin
      clearFlags();
      wr(1, acts[r] << 1);
      wr(5, 0);
      idle(10);
      check("R3 pin before match", int'(cmpOut[0]), (r == 0) ? 0 : pins[r-1]);
      idle(1);
      check("R3 pin after match", int'(cmpOut[0]), pins[r]);
      peek(4, v);
      check("R3 match flag", v & 1, 1);
    end
    check("R3 pin B untouched", int'(cmpOut[1]), 0);

    // R4 capture sense sweep
    for (int s = 0; s < 3; s++) begin
      wr(1, 1 | (s << 3));
      wr(6, 238);
      wr(5, 0);
      idle(5);
      capIn[0] = 1'b1;
      idle(5);
      chkReg("R4 capture after rise", 6, (s == 1) ? 238 : 7);
      capIn[0] = 1'b0;
      idle(5);
      chkReg("R4 capture after fall", 6, (s == 0) ? 7 : 12);
    end

    // R5 clear source sweep
    wr(1, 0); wr(2, 0);
    for (int src = 1; src <= 2; src++) begin
      for (int g = 0; g < 3; g++) begin
        wr(0, src << 5);
        wr(6, (src == 1) ? gvals[g] : 255);
        wr(7, (src == 2) ? gvals[g] : 255);
        wr(5, 0);
        idle(50);
        chkReg("R5 periodic clear", 5, 50 % (gvals[g] + 1));
      end
    end
    wr(6, 5); wr(7, 5);
    for (int src = 0; src <= 3; src += 3) begin
      wr(0, src << 5);
      wr(5, 0);
      idle(50);
      chkReg("R5 no clear source", 5, 50);
    end

    // R6 wrap flag, then wrap coinciding with clear
    wr(0, 4); wr(1, 1); wr(2, 1); wr(5, 253);
    clearFlags();
    wr(0, 0);
    idle(2);
    chkReg("R6 before wrap flag", 4, 0);
    idle(1);
    chkReg("R6 wrap flag", 4, 4);
    chkReg("R6 wrapped count", 5, 0);
    wr(0, 4); wr(1, 0); wr(6, 255); wr(5, 253);
    clearFlags();
    wr(0, 1 << 5);
    idle(3);
    chkReg("R6 clear suppresses wrap flag", 4, 1);
    chkReg("R6 cleared count", 5, 0);

    // R7 write beats advance and clear
    wr(0, 4); wr(6, 48); wr(5, 45);
    clearFlags();
    wr(0, 1 << 5);
    idle(3);
    wr(5, 85);
    chkReg("R7 write beats clear", 5, 85);
    peek(4, v);
    check("R7 match flag kept", v & 1, 1);
    wr(5, 64);
    chkReg("R7 write beats advance", 5, 64);

    // R8 capture beats write; read shows captured value
    wr(0, 0); wr(1, 1);
    wr(5, 0);
    idle(5);
    capIn[0] = 1'b1;
    idle(2);
    chkReg("R8 read during capture", 6, 7);
    wr(6, 153);
    chkReg("R8 capture beats write", 6, 7);
    capIn[0] = 1'b0;
    idle(4);

    // R9 write during compare match
    wr(0, 4); wr(1, 2 << 1); wr(6, 48); wr(5, 45);
    clearFlags();
    wr(0, 0);
    idle(3);
    wr(6, 128);
    chkReg("R9 write kept on match", 6, 128);
    peek(4, v);
    check("R9 flag on match", v & 1, 1);
    check("R9 pin action on match", int'(cmpOut[0]), 1);

    // R10 buffered compare
    wr(0, 4); wr(1, 32 | (3 << 1)); wr(6, 16); wr(8, 32); wr(5, 0);
    wr(0, 0);
    idle(20);
    chkReg("R10 buffer to GRA", 6, 32);
    check("R10 pin toggled", int'(cmpOut[0]), 0);
    wr(8, 48);
    idle(20);
    chkReg("R10 new buffer to GRA", 6, 48);
    check("R10 pin toggled again", int'(cmpOut[0]), 1);

    // R11 buffered capture
    wr(0, 4); wr(1, 32 | 1); wr(6, 17); wr(8, 34); wr(0, 0);
    wr(5, 0);
    idle(5);
    capIn[0] = 1'b1;
    idle(5);
    chkReg("R11 first capture", 6, 7);
    chkReg("R11 first shift", 8, 17);
    capIn[0] = 1'b0;
    idle(10);
    capIn[0] = 1'b1;
    idle(5);
    chkReg("R11 second capture", 6, 22);
    chkReg("R11 second shift", 8, 7);

    // R12 flag clear protocol
    wr(0, 4); wr(1, 1);
    capIn[0] = 1'b0;
    idle(4);
    clearFlags();
    chkReg("R12 cleared", 4, 0);
    capIn[0] = 1'b1;
    idle(5);
    chkReg("R12 flag set", 4, 1);
    wr(4, 0);
    chkReg("R12 clear without read ignored", 4, 1);
    readFlags();
    wr(4, 7);
    chkReg("R12 write one ignored", 4, 1);
    wr(4, 0);
    chkReg("R12 clear after read", 4, 0);

    // R13 interrupt enables
    capIn[0] = 1'b0; idle(4);
    capIn[0] = 1'b1; idle(5);
    wr(3, 0);
    check("R13 irq disabled", int'(irq), 0);
    wr(3, 2);
    check("R13 irq other enable", int'(irq), 0);
    wr(3, 1);
    check("R13 irq enabled", int'(irq), 1);
    clearFlags();
    check("R13 irq after clear", int'(irq), 0);
    wr(3, 4); wr(5, 254);
    wr(0, 0);
    idle(2);
    check("R13 irq on wrap", int'(irq), 1);
    wr(0, 4);

    summary();
    $finish;
  end
endmodule